// File: doc/BRIEF.md
# Overcurrent Fault Sequencer

This block sequences three escalating responses to overcurrent in a phase-shifted full-bridge controller. Two synchronous comparator flags drive it: a lower limit flag and a higher short-circuit flag. A counter stands in for the soft-start timing capacitor. The counter rises slowly during normal start-up and rises faster while the current limit keeps tripping. It is pulled down whenever a protective discharge is requested.

There are three responses, from mildest to strongest:
- The lower flag terminates only the conduction cycle in progress.
- If the lower flag trips on enough consecutive cycles, and the sequence-enable input allows it, a timer latch locks every bridge output off. The latch holds until the system-good reset.
- The higher flag raises a short-detect status, locks the outputs off and discharges the timer. Short-detect holds until the timer has fallen to a low threshold. The outputs come back once the timer has climbed past the enable threshold again.

Top module: `ocp_fault_seq`

## Requirements
- R1: While `rst_ni` is low, or at any clock edge where `sys_good_i` is low, the timer level goes to 0, all fault state clears, `lockout_o` is 1, and `discharge_o`, `short_det_o` and `pbp_cut_o` are 0.
- R2: With no discharge and no active limiting, the timer level rises by 1 every `SLOW_DIV` clock cycles, starting from reset, and saturates at `SS_CEIL`.
- R3: With no fault latched and no discharge pending, `lockout_o` falls at the clock edge after the one on which the timer level reaches `EN_TH`.
- R4: `pbp_cut_o` follows `pbp_hit_i` in the same cycle while the outputs are enabled. It is 0 while `lockout_o` is 1 and keeps no memory of earlier hits.
- R5: While the outputs are enabled and both `pbp_hit_i` and `seq_en_i` are high, the timer level rises by 1 on every clock edge, up to `SS_CEIL`.
- R6: If `pbp_hit_i` and `seq_en_i` are high on `INTEG_CYC` consecutive edges while enabled, then after the last of those edges `lockout_o` and `discharge_o` are 1. A single low cycle restarts the count.
- R7: While `seq_en_i` is low, sustained limiting never sets the timer latch.
- R8: Once the timer latch is set, `lockout_o` stays 1 through discharge and full recharge until `sys_good_i` goes low.
- R9: `oneshot_hit_i` sampled high sets `short_det_o`, `lockout_o` and `discharge_o` at that edge.
- R10: `short_det_o` clears at the edge after one on which the timer level is at or below `LOW_TH`, and not earlier. A further `oneshot_hit_i` while it is set has no effect.
- R11: During discharge the timer level drops by `DIS_STEP` per cycle and floors at 0. `discharge_o` clears at the edge after the level is 0, and the level then recharges per R2.
- R12: After a one-shot event has cleared, the outputs re-enable per R3 once the level climbs back to `EN_TH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sys_good_i | input | 1 | System-good; low acts as a synchronous clear |
| seq_en_i | input | 1 | Permits the timer latch when high |
| pbp_hit_i | input | 1 | Lower current-limit comparator flag |
| oneshot_hit_i | input | 1 | Higher short-circuit comparator flag |
| pbp_cut_o | output | 1 | Terminates the present conduction cycle |
| lockout_o | output | 1 | Forces all bridge and rectifier outputs off |
| discharge_o | output | 1 | Requests discharge of the soft-start timer |
| short_det_o | output | 1 | Short-circuit detected status |
| ss_level_o | output | SS_W | Present soft-start timer level |

## Verification
The limit flag is applied in several patterns:
- a single cycle, which separates the per-cycle cut from any latching;
- runs one shorter than the integration length, with a gap between them, which shows that the count restarts;
- a run of exactly the integration length, which sets the latch;
- a long run with sequence-enable low, which shows the latch is blocked.

A one-shot pulse at full timer level is followed edge by edge through the discharge ramp. This checks the exact cycle where short-detect clears relative to the low threshold, and the cycle where discharge ends at zero. Start-up and each recovery are timed from the last slow increment to the release of lockout. A repeated one-shot hit and a system-good drop check that short-detect ignores the extra hit and that the system-good drop clears the fault state.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef struct packed {
    logic tl_fire;  // integration run completed
    logic os_hit;   // short-circuit flag seen
  } fault_evt_t;
endpackage

// File: rtl/ocp_ss_timer.sv
module ocp_ss_timer #(
  parameter int SS_W     = 10,
  parameter int SS_CEIL  = 800,
  parameter int SLOW_DIV = 9,
  parameter int DIS_STEP = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            dis_i,
  input  logic            fast_i,
  output logic [SS_W-1:0] ss_o
);
  localparam int DIV_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [DIV_W-1:0] PRE_MAX = DIV_W'(SLOW_DIV - 1);
  localparam logic [SS_W-1:0]  CEIL_V  = SS_W'(SS_CEIL);
  localparam logic [SS_W-1:0]  STEP_V  = SS_W'(DIS_STEP);

  logic [DIV_W-1:0] pre_q;
  logic [SS_W-1:0]  ss_q;
  logic             tick;

  assign tick = (pre_q == PRE_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      ss_q  <= '0;
    end else if (clr_i) begin
      pre_q <= '0;
      ss_q  <= '0;
    end else if (dis_i) begin
      pre_q <= '0;
      ss_q  <= (ss_q >= STEP_V) ? ss_q - STEP_V : '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (ss_q < CEIL_V && (fast_i || tick)) ss_q <= ss_q + 1'b1;
    end
  end

  assign ss_o = ss_q;

  // R2: charging moves at most one step per cycle
  a_r2_one_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dis_i && !clr_i |=> {1'b0, ss_q} <= {1'b0, $past(ss_q)} + 1'b1);
  // R11: discharge strictly lowers a nonzero level
  a_r11_dis_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_i && !clr_i && ss_q != '0 |=> ss_q < $past(ss_q));
  a_r2_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_q <= CEIL_V);
endmodule

// File: rtl/ocp_integrator.sv
module ocp_integrator #(
  parameter int INTEG_CYC = 63
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic act_i,
  output logic fire_o
);
  localparam int IW = (INTEG_CYC > 1) ? $clog2(INTEG_CYC) : 1;
  localparam logic [IW-1:0] LAST = IW'(INTEG_CYC - 1);

  logic [IW-1:0] cnt_q;

  assign fire_o = act_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i || !act_i)    cnt_q <= '0;
    else if (cnt_q == LAST)      cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  initial begin
    a_r6_min_len: assert (INTEG_CYC >= 2);
  end

  // R6: a completed run needs limiting on the previous edge too
  a_r6_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o && !clr_i |-> $past(act_i));
endmodule

// File: rtl/ocp_fault_ctl.sv
module ocp_fault_ctl
  import ocp_pkg::*;
#(
  parameter int SS_W   = 10,
  parameter int EN_TH  = 756,
  parameter int LOW_TH = 80
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic [SS_W-1:0] ss_i,
  input  fault_evt_t      evt_i,
  output logic            en_o,
  output logic            dis_o,
  output logic            short_o
);
  localparam logic [SS_W-1:0] EN_V  = SS_W'(EN_TH);
  localparam logic [SS_W-1:0] LOW_V = SS_W'(LOW_TH);

  logic en_q, dis_q, short_q, latch_q;
  logic os_evt, any_evt;

  assign os_evt  = evt_i.os_hit && !short_q;
  assign any_evt = os_evt || evt_i.tl_fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      dis_q   <= 1'b0;
      short_q <= 1'b0;
      latch_q <= 1'b0;
    end else if (clr_i) begin
      en_q    <= 1'b0;
      dis_q   <= 1'b0;
      short_q <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      if (evt_i.tl_fire) latch_q <= 1'b1;

      if (os_evt)                          short_q <= 1'b1;
      else if (short_q && ss_i <= LOW_V)   short_q <= 1'b0;

      if (any_evt)                         dis_q <= 1'b1;
      else if (dis_q && ss_i == '0)        dis_q <= 1'b0;

      if (any_evt)                                   en_q <= 1'b0;
      else if (!dis_q && !latch_q && ss_i >= EN_V)   en_q <= 1'b1;
    end
  end

  assign en_o    = en_q;
  assign dis_o   = dis_q;
  assign short_o = short_q;

  a_r3_release_th: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_q) |-> $past(ss_i) >= EN_V);
  a_r8_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_q && !clr_i |=> latch_q && !en_q);
  a_r9_short_dis: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(short_q) |-> dis_q && !en_q);
  a_r10_short_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(short_q) |-> $past(clr_i) || $past(ss_i) <= LOW_V);
  a_r11_dis_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_q && ss_i == '0 && !clr_i && !evt_i.os_hit && !evt_i.tl_fire |=> !dis_q);
endmodule

// File: rtl/ocp_fault_seq.sv
module ocp_fault_seq
  import ocp_pkg::*;
#(
  parameter int SS_W      = 10,
  parameter int SS_CEIL   = 800,
  parameter int EN_TH     = 756,
  parameter int LOW_TH    = 80,
  parameter int SLOW_DIV  = 9,
  parameter int DIS_STEP  = 8,
  parameter int INTEG_CYC = 63
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sys_good_i,
  input  logic            seq_en_i,
  input  logic            pbp_hit_i,
  input  logic            oneshot_hit_i,
  output logic            pbp_cut_o,
  output logic            lockout_o,
  output logic            discharge_o,
  output logic            short_det_o,
  output logic [SS_W-1:0] ss_level_o
);
  logic            clr, en, dis, short_det, integ_act;
  logic [SS_W-1:0] ss;
  fault_evt_t      evt;

  assign clr       = !sys_good_i;
  assign integ_act = pbp_hit_i && seq_en_i && en;
  assign evt.os_hit = oneshot_hit_i;

  ocp_ss_timer #(
    .SS_W(SS_W), .SS_CEIL(SS_CEIL), .SLOW_DIV(SLOW_DIV), .DIS_STEP(DIS_STEP)
  ) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr),
    .dis_i(dis), .fast_i(integ_act), .ss_o(ss)
  );

  ocp_integrator #(.INTEG_CYC(INTEG_CYC)) u_integ (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr),
    .act_i(integ_act), .fire_o(evt.tl_fire)
  );

  ocp_fault_ctl #(.SS_W(SS_W), .EN_TH(EN_TH), .LOW_TH(LOW_TH)) u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .ss_i(ss),
    .evt_i(evt), .en_o(en), .dis_o(dis), .short_o(short_det)
  );

  assign pbp_cut_o   = pbp_hit_i && en;
  assign lockout_o   = !en;
  assign discharge_o = dis;
  assign short_det_o = short_det;
  assign ss_level_o  = ss;

  // R4: a cycle cut never coexists with lockout
  a_r4_cut_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pbp_cut_o |-> !lockout_o);
  // R7: no latch event while sequence-enable is low
  a_r7_seq_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seq_en_i |-> !evt.tl_fire);
endmodule

// File: tb/ocp_fault_seq_tb.sv
module ocp_fault_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SS_W = 6, CEIL = 48, EN_TH = 45, LOW_TH = 5;
  localparam int SDIV = 4, DSTEP = 2, INTEG = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sys_good = 1'b0, seq_en = 1'b0, pbp = 1'b0, os = 1'b0;
  logic cut, lock, dis, shrt;
  logic [SS_W-1:0] ss;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ocp_fault_seq #(
    .SS_W(SS_W), .SS_CEIL(CEIL), .EN_TH(EN_TH), .LOW_TH(LOW_TH),
    .SLOW_DIV(SDIV), .DIS_STEP(DSTEP), .INTEG_CYC(INTEG)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sys_good_i(sys_good), .seq_en_i(seq_en),
    .pbp_hit_i(pbp), .oneshot_hit_i(os), .pbp_cut_o(cut), .lockout_o(lock),
    .discharge_o(dis), .short_det_o(shrt), .ss_level_o(ss)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // wait for the last slow step below EN_TH, then time the release
  task automatic wait_release(input string tag);
    int k = 0;
    while (int'(ss) != EN_TH - 1 && k < 2000) begin step(1); k++; end
    chk({tag, " level seen"}, int'(ss), EN_TH - 1);
    chk({tag, " locked below threshold"}, lock, 1);
    k = 0;
    while (lock && k < 50) begin step(1); k++; end
    chk({tag, " cycles to release"}, k, SDIV + 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int k;
    step(2);
    // R1 reset state
    chk("R1 reset lockout", lock, 1);
    chk("R1 reset level", int'(ss), 0);
    chk("R1 reset discharge", dis, 0);
    chk("R1 reset short", shrt, 0);
    sys_good = 1'b1;
    rst_n = 1'b1;
    // R2 slow charge
    step(2 * SDIV - 1);
    chk("R2 level after 7 cycles", int'(ss), 1);
    step(1);
    chk("R2 level after 8 cycles", int'(ss), 2);
    // R4 cut blocked during lockout
    pbp = 1'b1; #1;
    chk("R4 cut while locked", cut, 0);
    step(1); pbp = 1'b0;
    // R3 release timing
    wait_release("R3");
    // R5 fast charge: level at EN_TH, three limited cycles
    chk("R5 start level", int'(ss), EN_TH);
    pbp = 1'b1; seq_en = 1'b1; #1;
    chk("R4 cut follows hit", cut, 1);
    step(3);
    chk("R5 fast level", int'(ss), EN_TH + 3);
    pbp = 1'b0; #1;
    chk("R4 cut no memory", cut, 0);
    chk("R5 no lockout", lock, 0);
    // R6 interrupted runs do not latch
    step(1);
    pbp = 1'b1; step(INTEG - 1); pbp = 1'b0; step(1);
    pbp = 1'b1; step(INTEG - 1); pbp = 1'b0; step(1);
    chk("R6 interrupted runs", lock, 0);
    // R7 sustained limiting with seq_en low
    seq_en = 1'b0; pbp = 1'b1; step(4 * INTEG);
    chk("R7 no latch", lock, 0);
    chk("R7 cut active", cut, 1);
    pbp = 1'b0; seq_en = 1'b1; step(1);
    // R6 full run latches
    pbp = 1'b1; step(INTEG - 1);
    chk("R6 one short of run", lock, 0);
    step(1);
    chk("R6 lockout", lock, 1);
    chk("R6 discharge", dis, 1);
    pbp = 1'b0;
    // R8 latch holds through discharge and recharge
    step(300);
    chk("R8 recharged", int'(ss), CEIL);
    chk("R8 discharge done", dis, 0);
    chk("R8 still locked", lock, 1);
    chk("R8 no short", shrt, 0);
    // R1 sys_good clear
    sys_good = 1'b0; step(1);
    chk("R1 clear level", int'(ss), 0);
    chk("R1 clear lockout", lock, 1);
    sys_good = 1'b1;
    wait_release("R1 restart");
    step(SDIV * (CEIL - EN_TH) + 2);
    chk("R2 saturates", int'(ss), CEIL);
    // R9 one-shot
    os = 1'b1; step(1); os = 1'b0;
    chk("R9 short set", shrt, 1);
    chk("R9 lockout", lock, 1);
    chk("R9 discharge", dis, 1);
    chk("R11 level held at event", int'(ss), CEIL);
    step(1);
    chk("R11 first step", int'(ss), CEIL - DSTEP);
    os = 1'b1; step(1); os = 1'b0;  // R10 repeat hit ignored
    chk("R10 repeat hit", int'(ss), CEIL - 2 * DSTEP);
    k = 0;
    while (int'(ss) > LOW_TH && k < 100) begin
      if (!shrt) chk("R10 short held above low", shrt, 1);
      step(1); k++;
    end
    chk("R10 short at low", shrt, 1);
    chk("R10 level at low", int'(ss), 4);
    step(1);
    chk("R10 short cleared", shrt, 0);
    chk("R11 level", int'(ss), 2);
    step(1);
    chk("R11 floor", int'(ss), 0);
    chk("R11 discharge at zero", dis, 1);
    step(1);
    chk("R11 discharge ended", dis, 0);
    chk("R11 level stays", int'(ss), 0);
    // R12 recovery
    wait_release("R12");
    // R1 sys_good clears short
    os = 1'b1; step(1); os = 1'b0;
    chk("R9 short again", shrt, 1);
    sys_good = 1'b0; step(1);
    chk("R1 short cleared", shrt, 0);
    chk("R1 discharge cleared", dis, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule